// File: doc/BRIEF.md
# Source Data Pointer Selection Unit

This unit keeps the address registers that a processor uses to read data memory: two independent data pointers, a frame base register, an 8-bit frame offset register and a small control register. From these it derives the current source address for memory loads, the access width (word or byte) that goes with that pointer, and a flag that says whether any source pointer has been made active since reset. The frame pointer is the unsigned sum of base and offset. The offset can also be stepped up or down by dedicated strobes, which leave the base untouched.

Software reaches every register through a plain register port: an address, a write enable and write data, with read data returned combinationally for the addressed register. Writing a pointer register also moves the select field in the control register so that the pointer just written becomes the source. The port carries single-cycle register accesses rather than a data stream, so it has no valid/ready handshake and no back-pressure: each write strobe is taken in the cycle it is high, and the source outputs follow the registers combinationally.

Top module: `dptr_select_unit`

## Requirements
- R1: Register addresses are 0 = first data pointer, 1 = second data pointer, 2 = frame base, 3 = frame offset (8 bits, read zero-extended), 4 = control; every register reads back what was written to it, unmapped addresses 5 to 7 read 0, and writes to them change nothing (including the valid flag).
- R2: After reset the control register reads 001Ch, both data pointers, base and offset read 0, and src_valid is low.
- R3: Control bits [1:0] choose the source: 00 the first data pointer, 01 the second, 10 and 11 the frame pointer; src_addr carries the chosen address.
- R4: Control bit 2 is the width mode of the first data pointer, bit 3 of the second and bit 4 of the frame pointer; src_word shows the mode of the selected pointer, 1 for word and 0 for byte.
- R5: Control bits [15:5] always read 0; writing ones to them has no effect.
- R6: src_valid stays low after reset until a control write or a write to any of the four pointer registers; once high it stays high until the next reset. Offset steps do not raise it.
- R7: A write to the first data pointer sets the select field to 00, to the second to 01, and to base or offset to 10; the mode bits are not changed by these writes.
- R8: The frame address is base plus zero-extended offset, modulo 2^16.
- R9: offs_inc adds 1 to the offset and offs_dec subtracts 1, both modulo 256; both together leave it unchanged; neither strobe changes base, the select field or src_valid.
- R10: When a register write to the offset coincides with an offset step, the written value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| offs_inc | input | 1 | Step the frame offset up by one |
| offs_dec | input | 1 | Step the frame offset down by one |
| src_addr | output | 16 | Active source address for data-memory reads |
| src_word | output | 1 | Width mode of the active pointer (1 word, 0 byte) |
| src_valid | output | 1 | A source pointer has been activated since reset |

## Verification
The bench first goes after the activation gate: a design that treated the reset select value as already active would raise src_valid straight out of reset or after a mere offset step, and one that let an unmapped write activate would do the same. It drives the frame sum across the 16-bit boundary and the offset across 00h/FFh in both directions, where a design that kept the carry or widened the offset would show a wrong address. It sets the reserved select code 11 and reserved control bits, which a loose decoder would turn into a dead select or stray read-back bits, and it lands an offset write on top of a step strobe, where a design with the wrong priority would store the stepped value.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned NUM_DP = 2;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned MODE_W = NUM_DP + 1;
  localparam int unsigned CTRL_W = SEL_W + MODE_W;

  typedef enum logic [REG_AW-1:0] {
    RA_DP0  = 3'd0,
    RA_DP1  = 3'd1,
    RA_BASE = 3'd2,
    RA_OFFS = 3'd3,
    RA_CTRL = 3'd4
  } reg_addr_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_DP0   = 2'b00,
    SEL_DP1   = 2'b01,
    SEL_FRAME = 2'b10,
    SEL_RSVD  = 2'b11
  } src_sel_e;

  localparam logic [MODE_W-1:0] MODE_RST = '1;
endpackage

// File: rtl/dptr_ptr_regs.sv
module dptr_ptr_regs
  import dptr_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned OW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [REG_AW-1:0]          addr,
  input  logic [DW-1:0]              wdata,
  input  logic                       step_up,
  input  logic                       step_dn,
  output logic [NUM_DP-1:0][DW-1:0]  dp_q,
  output logic [DW-1:0]              base_q,
  output logic [OW-1:0]              offs_q,
  output logic                       ptr_wr,
  output logic [SEL_W-1:0]           ptr_sel
);
  localparam logic [OW-1:0] OFFS_ONE = OW'(1);

  logic wr_base, wr_offs;
  logic [NUM_DP-1:0] wr_dp;

  assign wr_base = wr_en && (addr == RA_BASE);
  assign wr_offs = wr_en && (addr == RA_OFFS);

  for (genvar g = 0; g < NUM_DP; g++) begin : g_dp
    assign wr_dp[g] = wr_en && (addr == REG_AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dp_q[g] <= '0;
      else if (wr_dp[g]) dp_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (wr_base) base_q <= wdata;
  end

  // A register write outranks a step strobe; opposing strobes cancel.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  offs_q <= '0;
    else if (wr_offs)            offs_q <= wdata[OW-1:0];
    else if (step_up && !step_dn) offs_q <= offs_q + OFFS_ONE;
    else if (step_dn && !step_up) offs_q <= offs_q - OFFS_ONE;
  end

  assign ptr_wr = (|wr_dp) || wr_base || wr_offs;

  always_comb begin
    ptr_sel = SEL_FRAME;
    if (wr_dp[0])      ptr_sel = SEL_DP0;
    else if (wr_dp[1]) ptr_sel = SEL_DP1;
  end
endmodule

// File: rtl/dptr_ctrl.sv
module dptr_ctrl
  import dptr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              ptr_wr,
  input  logic [SEL_W-1:0]  ptr_sel,
  output logic [SEL_W-1:0]  sel_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              active_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= SEL_DP0;
      mode_q   <= MODE_RST;
      active_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        sel_q    <= ctrl_wdata[SEL_W-1:0];
        mode_q   <= ctrl_wdata[CTRL_W-1:SEL_W];
        active_q <= 1'b1;
      end
      // Pointer writes are applied last so they decide the select field.
      if (ptr_wr) begin
        sel_q    <= ptr_sel;
        active_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dptr_src_mux.sv
module dptr_src_mux
  import dptr_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned OW = 8
) (
  input  logic [SEL_W-1:0]          sel,
  input  logic [MODE_W-1:0]         mode,
  input  logic [NUM_DP-1:0][DW-1:0] dp_q,
  input  logic [DW-1:0]             base_q,
  input  logic [OW-1:0]             offs_q,
  output logic [DW-1:0]             src_addr,
  output logic                      src_word
);
  logic [DW-1:0] frame_addr;

  assign frame_addr = base_q + DW'(offs_q);

  always_comb begin
    unique case (sel)
      SEL_DP0: begin
        src_addr = dp_q[0];
        src_word = mode[0];
      end
      SEL_DP1: begin
        src_addr = dp_q[1];
        src_word = mode[1];
      end
      default: begin
        src_addr = frame_addr;
        src_word = mode[NUM_DP];
      end
    endcase
  end
endmodule

// File: rtl/dptr_select_unit.sv
module dptr_select_unit
  import dptr_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned OW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              offs_inc,
  input  logic              offs_dec,
  output logic [DW-1:0]     src_addr,
  output logic              src_word,
  output logic              src_valid
);
  logic [NUM_DP-1:0][DW-1:0] dp_q;
  logic [DW-1:0]             base_q;
  logic [OW-1:0]             offs_q;
  logic                      ptr_wr;
  logic [SEL_W-1:0]          ptr_sel;
  logic [SEL_W-1:0]          sel_q;
  logic [MODE_W-1:0]         mode_q;
  logic                      ctrl_wr;

  assign ctrl_wr = reg_wr_en && (reg_addr == RA_CTRL);

  dptr_ptr_regs #(.DW(DW), .OW(OW)) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .step_up (offs_inc),
    .step_dn (offs_dec),
    .dp_q    (dp_q),
    .base_q  (base_q),
    .offs_q  (offs_q),
    .ptr_wr  (ptr_wr),
    .ptr_sel (ptr_sel)
  );

  dptr_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (reg_wdata[CTRL_W-1:0]),
    .ptr_wr     (ptr_wr),
    .ptr_sel    (ptr_sel),
    .sel_q      (sel_q),
    .mode_q     (mode_q),
    .active_q   (src_valid)
  );

  dptr_src_mux #(.DW(DW), .OW(OW)) i_mux (
    .sel      (sel_q),
    .mode     (mode_q),
    .dp_q     (dp_q),
    .base_q   (base_q),
    .offs_q   (offs_q),
    .src_addr (src_addr),
    .src_word (src_word)
  );

  always_comb begin
    case (reg_addr)
      RA_DP0:  reg_rdata = dp_q[0];
      RA_DP1:  reg_rdata = dp_q[1];
      RA_BASE: reg_rdata = base_q;
      RA_OFFS: reg_rdata = DW'(offs_q);
      RA_CTRL: reg_rdata = DW'({mode_q, sel_q});
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dptr_select_checker.sv
module dptr_select_checker
  import dptr_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned OW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DW-1:0]     reg_wdata,
  input logic [DW-1:0]     reg_rdata,
  input logic              offs_inc,
  input logic              offs_dec,
  input logic [DW-1:0]     src_addr,
  input logic              src_valid,
  input logic [DW-1:0]     base_q,
  input logic [OW-1:0]     offs_q
);
  logic wr_mapped;
  assign wr_mapped = reg_wr_en && (reg_addr <= RA_CTRL);

  a_r7_dp0_takes_source: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == RA_DP0) |=> (src_addr == $past(reg_wdata)) && src_valid);

  a_r7_dp1_takes_source: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == RA_DP1) |=> (src_addr == $past(reg_wdata)) && src_valid);

  a_r8_base_write_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == RA_BASE) |=> src_addr == DW'($past(reg_wdata) + DW'(offs_q)));

  a_r6_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid |=> src_valid);

  a_r6_valid_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_valid && !wr_mapped) |=> !src_valid);

  a_r5_ctrl_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RA_CTRL) |-> (reg_rdata[DW-1:CTRL_W] == '0));

  a_r9_base_kept_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    ((offs_inc || offs_dec) && !(reg_wr_en && reg_addr == RA_BASE)) |=> $stable(base_q));

  a_r9_offs_inc_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (offs_inc && !offs_dec && !(reg_wr_en && reg_addr == RA_OFFS))
      |=> offs_q == OW'($past(offs_q) + OW'(1)));

  a_r10_write_beats_step: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == RA_OFFS) |=> offs_q == $past(reg_wdata[OW-1:0]));
endmodule

bind dptr_select_unit dptr_select_checker #(.DW(DW), .OW(OW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .offs_inc  (offs_inc),
  .offs_dec  (offs_dec),
  .src_addr  (src_addr),
  .src_valid (src_valid),
  .base_q    (base_q),
  .offs_q    (offs_q)
);

// File: tb/test_dptr_select_unit.sv
module test_dptr_select_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        offs_inc = 1'b0;
  logic        offs_dec = 1'b0;
  logic [15:0] src_addr;
  logic        src_word;
  logic        src_valid;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dptr_select_unit i_dptr_select_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .offs_inc(offs_inc),
    .offs_dec(offs_dec), .src_addr(src_addr), .src_word(src_word),
    .src_valid(src_valid)
  );

  // Vector: wr(1) addr(3) wdata(16) inc(1) dec(1) | exp_addr(16) exp_word(1) exp_valid(1)
  localparam int NV = 12;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 3'd1, 16'h1234, 1'b0, 1'b0, 16'h1234, 1'b1, 1'b1}, // R7 dp1 write selects 01
    {1'b1, 3'd0, 16'hABCD, 1'b0, 1'b0, 16'hABCD, 1'b1, 1'b1}, // R7 dp0 write selects 00
    {1'b1, 3'd4, 16'h0001, 1'b0, 1'b0, 16'h1234, 1'b0, 1'b1}, // R3 sel 01, R4 byte
    {1'b1, 3'd2, 16'hFFF0, 1'b0, 1'b0, 16'hFFF0, 1'b0, 1'b1}, // R7 base -> frame
    {1'b1, 3'd3, 16'h0025, 1'b0, 1'b0, 16'h0015, 1'b0, 1'b1}, // R8 carry dropped
    {1'b0, 3'd0, 16'h0000, 1'b1, 1'b0, 16'h0016, 1'b0, 1'b1}, // R9 inc
    {1'b1, 3'd4, 16'h0013, 1'b0, 1'b0, 16'h0016, 1'b1, 1'b1}, // R3 sel 11 = frame, R4
    {1'b0, 3'd0, 16'h0000, 1'b0, 1'b1, 16'h0015, 1'b1, 1'b1}, // R9 dec
    {1'b1, 3'd4, 16'h0008, 1'b0, 1'b0, 16'hABCD, 1'b0, 1'b1}, // R3 sel 00, R4 bit2 byte
    {1'b1, 3'd4, 16'h0009, 1'b0, 1'b0, 16'h1234, 1'b1, 1'b1}, // R3 sel 01, R4 bit3 word
    {1'b1, 3'd0, 16'h0F00, 1'b0, 1'b0, 16'h0F00, 1'b0, 1'b1}, // R7 back to dp0
    {1'b0, 3'd0, 16'h0000, 1'b1, 1'b1, 16'h0F00, 1'b0, 1'b1}  // R9 both strobes
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic op(input bit wr, input logic [2:0] a, input logic [15:0] d,
                    input bit inc, input bit dec);
    reg_wr_en = wr; reg_addr = a; reg_wdata = d; offs_inc = inc; offs_dec = dec;
    @(posedge clk);
    #1;
    reg_wr_en = 1'b0; offs_inc = 1'b0; offs_dec = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    @(negedge clk);
    do_reset();

    // R2: reset state
    check(src_valid == 1'b0, "R2 valid low", 32'(src_valid), 0);
    rd(3'd4, v); check(v == 16'h001C, "R2 ctrl reset", 32'(v), 32'h1C);
    rd(3'd0, v); check(v == 16'h0000, "R2 dp0 reset", 32'(v), 0);
    rd(3'd3, v); check(v == 16'h0000, "R2 offs reset", 32'(v), 0);
    check(src_word == 1'b1, "R4 reset word mode", 32'(src_word), 1);

    // R6/R1: offset step and unmapped write do not activate
    op(1'b0, 3'd0, 16'h0, 1'b1, 1'b0);
    check(src_valid == 1'b0, "R6 step keeps valid low", 32'(src_valid), 0);
    op(1'b1, 3'd7, 16'hFFFF, 1'b0, 1'b0);
    check(src_valid == 1'b0, "R1 unmapped write ignored", 32'(src_valid), 0);
    rd(3'd7, v); check(v == 16'h0000, "R1 unmapped reads 0", 32'(v), 0);
    rd(3'd0, v); check(v == 16'h0000, "R1 dp0 untouched", 32'(v), 0);
    rd(3'd3, v); check(v == 16'h0001, "R9 offs stepped", 32'(v), 1);
    op(1'b1, 3'd4, 16'h001C, 1'b0, 1'b0);
    check(src_valid == 1'b1, "R6 ctrl write activates", 32'(src_valid), 1);

    // Vector table from a fresh reset
    do_reset();
    for (int i = 0; i < NV; i++) begin
      logic [39:0] e;
      e = VEC[i];
      op(e[39], e[38:36], e[35:20], e[19], e[18]);
      check(src_addr == e[17:2], $sformatf("R3/R8 vec%0d addr", i), 32'(src_addr), 32'(e[17:2]));
      check(src_word == e[1], $sformatf("R4 vec%0d word", i), 32'(src_word), 32'(e[1]));
      check(src_valid == e[0], $sformatf("R6 vec%0d valid", i), 32'(src_valid), 32'(e[0]));
    end

    // R5: reserved control bits
    op(1'b1, 3'd4, 16'hFFFF, 1'b0, 1'b0);
    rd(3'd4, v); check(v == 16'h001F, "R5 reserved bits read 0", 32'(v), 32'h1F);

    // R7: pointer write keeps modes, changes select
    op(1'b1, 3'd4, 16'h0004, 1'b0, 1'b0);
    op(1'b1, 3'd2, 16'h1000, 1'b0, 1'b0);
    rd(3'd4, v); check(v == 16'h0006, "R7 base write sets 10 keeps modes", 32'(v), 32'h6);
    op(1'b1, 3'd1, 16'h2222, 1'b0, 1'b0);
    rd(3'd4, v); check(v == 16'h0005, "R7 dp1 write sets 01", 32'(v), 32'h5);
    rd(3'd1, v); check(v == 16'h2222, "R1 dp1 readback", 32'(v), 32'h2222);

    // R9: offset wrap both ways, base kept, both strobes
    op(1'b1, 3'd3, 16'h00FF, 1'b0, 1'b0);
    check(src_addr == 16'h10FF, "R8 frame sum", 32'(src_addr), 32'h10FF);
    op(1'b0, 3'd0, 16'h0, 1'b1, 1'b0);
    rd(3'd3, v); check(v == 16'h0000, "R9 inc wraps", 32'(v), 0);
    rd(3'd2, v); check(v == 16'h1000, "R9 base kept", 32'(v), 32'h1000);
    op(1'b0, 3'd0, 16'h0, 1'b0, 1'b1);
    rd(3'd3, v); check(v == 16'h00FF, "R9 dec wraps", 32'(v), 32'hFF);
    op(1'b0, 3'd0, 16'h0, 1'b1, 1'b1);
    rd(3'd3, v); check(v == 16'h00FF, "R9 both strobes hold", 32'(v), 32'hFF);
    rd(3'd4, v); check(v == 16'h0006, "R9 step keeps select", 32'(v), 32'h6);

    // R10: write beats step
    op(1'b1, 3'd3, 16'h0010, 1'b1, 1'b0);
    rd(3'd3, v); check(v == 16'h0010, "R10 write beats inc", 32'(v), 32'h10);
    op(1'b1, 3'd3, 16'h0040, 1'b0, 1'b1);
    rd(3'd3, v); check(v == 16'h0040, "R10 write beats dec", 32'(v), 32'h40);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule